// File: doc/BRIEF.md
# Multi-Port GPIO Register Block on APB

This block is a single APB slave that drives and observes up to four groups of general-purpose lines, each up to 32 lines wide. Software writes an output value word and a line-direction word per group. A line whose direction bit is set drives its stored output value, with its output-enable asserted. A line whose direction bit is clear is an input. The current level of every group's inputs can be read from a separate read-only window.

The value and direction words of the groups are interleaved with a 12-byte step. The input-level words sit together in a dense window of 4-byte steps starting at offset 0x50. Every input passes through a two-flop synchroniser before software can see it. Each group's line count is a parameter. Bits above that count do not exist: they read as zero, are never driven, and ignore writes.

Top module: `gpio_apb_regs`

## Requirements
- R1: While `presetn` is low at a rising edge, every value and direction word clears. After that edge `pin_out` and `pin_oe` are all zero, so every line is an input.
- R2: A write to offset 0x0C*g (group g = 0..3) stores `pwdata` as group g's output value. The stored value is driven on `pin_out[32*g +: 32]` and read back from the same offset.
- R3: A write to offset 0x0C*g + 0x04 stores group g's direction word, which is driven on `pin_oe[32*g +: 32]` and read back from the same offset. A 1 marks the line as an output and a 0 marks it as an input.
- R4: A read of offset 0x50 + 4*g returns group g's `pin_in` slice as it was two rising edges earlier. A level change applied between two edges is absent after the first edge and visible after the second.
- R5: For a group configured with W lines, bits W..31 of its value, direction and input-level words read as zero. The matching `pin_out` and `pin_oe` bits stay zero, and writes to those bits are dropped.
- R6: Offsets that map to no register read as zero, and writes to them change no register. This covers offsets with nonzero low two bits, offset 0x08, offsets above 0x5C, and groups beyond the configured count.
- R7: Writes to the input-level window (0x50..0x5C) leave every value and direction word unchanged.
- R8: A write to one group's word leaves every other group's words unchanged.
- R9: `pready` is always 1. A register is written only at a rising edge where `psel`, `penable` and `pwrite` are all high. A setup-phase cycle alone (with `penable` low) writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high |
| pready | output | 1 | Always ready (no wait states) |
| pin_in | input | 128 | Raw line levels, 32 per group |
| pin_out | output | 128 | Output values, 32 per group |
| pin_oe | output | 128 | Output enables, 32 per group |

## Verification
A write takes effect at the single rising edge that ends its access phase. Its result is therefore due on `pin_out`, `pin_oe` and a following read one edge after that access. Read data is combinational from the stored words, so the bench drives all inputs and samples all outputs on falling edges, where every register has settled. The synchroniser result is due two rising edges after a pin change. To check that exact latency, the bench holds a read of the input-level window open. It then checks that the old value remains after one edge and that the new value appears after the second.

// File: rtl/gpio_pkg.sv
// Shared constants and helpers for the GPIO register block.
// Assumes 32-bit words and at most four line groups.
package gpio_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned MAX_GROUPS = 4;
    localparam int unsigned GRP_STEP_W = 3;    // 12-byte step in words
    localparam int unsigned LVL_BASE_W = 20;   // 0x50 in words

    // Mask with the low w bits set.
    function automatic logic [WORD_W-1:0] line_mask(input int unsigned w);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (i < w);
        return m;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for a bus of independent input levels.
// Assumes each bit is sampled on its own; no coherence across bits is implied.
module gpio_in_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R4
    two_edge_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_group_bank.sv
// Storage for one line group: output value word, direction word and the
// synchronised input levels. Assumes the decoder gives one-cycle write strobes.
module gpio_group_bank
    import gpio_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_val,
    input  logic              wr_dir,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] pins,
    output logic [WORD_W-1:0] val_q,
    output logic [WORD_W-1:0] dir_q,
    output logic [WORD_W-1:0] lvl_q
);
    localparam logic [WORD_W-1:0] MASK = line_mask(LINES);

    // Capture software writes into the value and direction words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_val) val_q <= wdata & MASK;
            if (wr_dir) dir_q <= wdata & MASK;
        end
    end

    gpio_in_sync #(.WIDTH(WORD_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins & MASK),
        .q    (lvl_q)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (val_q == '0 && dir_q == '0));
    // R7
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_val |=> $stable(val_q));
    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));
    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((val_q & ~MASK) == '0) && ((dir_q & ~MASK) == '0) && ((lvl_q & ~MASK) == '0));
endmodule

// File: rtl/gpio_apb_regs.sv
// APB slave exposing up to four GPIO line groups. Value/direction words sit
// at a 12-byte step from 0; input-level words at a 4-byte step from 0x50.
// Assumes zero-wait transfers and word-aligned accesses only.
module gpio_apb_regs
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NGROUPS = 4,
    parameter int unsigned LINES0  = 32,
    parameter int unsigned LINES1  = 16,
    parameter int unsigned LINES2  = 8,
    parameter int unsigned LINES3  = 4
) (
    input  logic                         pclk,
    input  logic                         presetn,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [ADDR_W-1:0]            paddr,
    input  logic [WORD_W-1:0]            pwdata,
    output logic [WORD_W-1:0]            prdata,
    output logic                         pready,
    input  logic [MAX_GROUPS*WORD_W-1:0] pin_in,
    output logic [MAX_GROUPS*WORD_W-1:0] pin_out,
    output logic [MAX_GROUPS*WORD_W-1:0] pin_oe
);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam int unsigned LINES_G [MAX_GROUPS] = '{LINES0, LINES1, LINES2, LINES3};

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              wr_go;
    logic [WORD_W-1:0] val_q [NGROUPS];
    logic [WORD_W-1:0] dir_q [NGROUPS];
    logic [WORD_W-1:0] lvl_q [NGROUPS];
    logic [NGROUPS-1:0] hit_val, hit_dir, hit_lvl;

    assign widx    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_go   = psel && penable && pwrite;
    assign pready  = 1'b1;

    genvar g;
    generate
        for (g = 0; g < NGROUPS; g++) begin : g_grp
            // Decode the three words owned by group g.
            always_comb begin
                hit_val[g] = aligned && (widx == WIDX_W'(GRP_STEP_W*g));
                hit_dir[g] = aligned && (widx == WIDX_W'(GRP_STEP_W*g + 1));
                hit_lvl[g] = aligned && (widx == WIDX_W'(LVL_BASE_W + g));
            end

            gpio_group_bank #(.LINES(LINES_G[g])) u_bank (
                .clk   (pclk),
                .rst_n (presetn),
                .wr_val(wr_go && hit_val[g]),
                .wr_dir(wr_go && hit_dir[g]),
                .wdata (pwdata),
                .pins  (pin_in[g*WORD_W +: WORD_W]),
                .val_q (val_q[g]),
                .dir_q (dir_q[g]),
                .lvl_q (lvl_q[g])
            );

            assign pin_out[g*WORD_W +: WORD_W] = val_q[g];
            assign pin_oe [g*WORD_W +: WORD_W] = dir_q[g];
        end
        for (g = NGROUPS; g < MAX_GROUPS; g++) begin : g_absent
            assign pin_out[g*WORD_W +: WORD_W] = '0;
            assign pin_oe [g*WORD_W +: WORD_W] = '0;
        end
    endgenerate

    // Select the read word for the addressed register, zero when unmapped.
    always_comb begin
        prdata = '0;
        if (psel) begin
            for (int i = 0; i < NGROUPS; i++) begin
                if (hit_val[i]) prdata = val_q[i];
                if (hit_dir[i]) prdata = dir_q[i];
                if (hit_lvl[i]) prdata = lvl_q[i];
            end
        end
    end

    // R6
    unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !aligned) |-> (prdata == '0));
    // R9
    setup_nowrite_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

// File: tb/gpio_apb_regs_tb.sv
module gpio_apb_regs_tb;
    logic         pclk = 1'b0;
    logic         presetn;
    logic         psel, penable, pwrite;
    logic [7:0]   paddr;
    logic [31:0]  pwdata;
    logic [31:0]  prdata;
    logic         pready;
    logic [127:0] pin_in;
    logic [127:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 pclk = ~pclk;

    gpio_apb_regs u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 val0", 8'h00, 32'h0);
        rd_chk("R1 dir0", 8'h04, 32'h0);
        rd_chk("R1 dir3", 8'h28, 32'h0);
        chk("R1 oe", 32'(|pin_oe), 32'h0);
        chk("R1 out", 32'(|pin_out), 32'h0);
        chk("R9 pready", 32'(pready), 32'h1);
    endtask

    task automatic t_write_groups();
        apb_wr(8'h00, 32'hDEADBEEF);
        chk("R2 out0", pin_out[31:0], 32'hDEADBEEF);
        rd_chk("R2 val0", 8'h00, 32'hDEADBEEF);
        apb_wr(8'h04, 32'h0000FFFF);
        chk("R3 oe0", pin_oe[31:0], 32'h0000FFFF);
        rd_chk("R3 dir0", 8'h04, 32'h0000FFFF);
        apb_wr(8'h18, 32'h000000A5);
        chk("R2 out2", pin_out[95:64], 32'h000000A5);
        rd_chk("R8 val0 kept", 8'h00, 32'hDEADBEEF);
        rd_chk("R8 dir0 kept", 8'h04, 32'h0000FFFF);
        chk("R8 out1 kept", pin_out[63:32], 32'h0);
    endtask

    task automatic t_width();
        apb_wr(8'h0C, 32'hFFFFFFFF);
        rd_chk("R5 val1", 8'h0C, 32'h0000FFFF);
        chk("R5 out1", pin_out[63:32], 32'h0000FFFF);
        apb_wr(8'h28, 32'hFFFFFFFF);
        rd_chk("R5 dir3", 8'h28, 32'h0000000F);
        chk("R5 oe3", pin_oe[127:96], 32'h0000000F);
        pin_in[63:32] = 32'hFFFFFFFF;
        repeat (3) @(negedge pclk);
        rd_chk("R5 lvl1", 8'h54, 32'h0000FFFF);
    endtask

    task automatic t_sync();
        @(negedge pclk);
        psel = 1; pwrite = 0; paddr = 8'h50; penable = 1;
        pin_in[31:0] = 32'hA5A50F0F;
        #1 chk("R4 before edge", prdata, 32'h0);
        @(negedge pclk);
        chk("R4 after one edge", prdata, 32'h0);
        @(negedge pclk);
        chk("R4 after two edges", prdata, 32'hA5A50F0F);
        psel = 0; penable = 0;
    endtask

    task automatic t_ignored();
        apb_wr(8'h50, 32'h12345678);
        apb_wr(8'h54, 32'h0);
        rd_chk("R7 val0", 8'h00, 32'hDEADBEEF);
        rd_chk("R7 dir0", 8'h04, 32'h0000FFFF);
        rd_chk("R7 lvl0", 8'h50, 32'hA5A50F0F);
        apb_wr(8'h08, 32'hCAFEF00D);
        apb_wr(8'h01, 32'h0);
        apb_wr(8'h60, 32'h0);
        rd_chk("R6 rd 08", 8'h08, 32'h0);
        rd_chk("R6 rd 01", 8'h01, 32'h0);
        rd_chk("R6 rd 60", 8'h60, 32'h0);
        rd_chk("R6 val0 kept", 8'h00, 32'hDEADBEEF);
        chk("R6 out0 kept", pin_out[31:0], 32'hDEADBEEF);
    endtask

    task automatic t_setup_only();
        @(negedge pclk);
        psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'h0; penable = 0;
        @(negedge pclk);
        psel = 0; pwrite = 0;
        chk("R9 setup no write", pin_out[31:0], 32'hDEADBEEF);
        rd_chk("R9 val0", 8'h00, 32'hDEADBEEF);
    endtask

    task automatic t_reset_again();
        @(negedge pclk);
        presetn = 0;
        @(negedge pclk);
        presetn = 1;
        chk("R1 out after reset", 32'(|pin_out), 32'h0);
        chk("R1 oe after reset", 32'(|pin_oe), 32'h0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        presetn = 0; psel = 0; penable = 0; pwrite = 0;
        paddr = '0; pwdata = '0; pin_in = '0;
        repeat (4) @(negedge pclk);
        presetn = 1;
        t_reset();
        t_write_groups();
        t_width();
        t_sync();
        t_ignored();
        t_setup_only();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule